// File: doc/BRIEF.md
# Raster Interrupt and Status Flag Controller

This block sits inside a tile-based video display processor. It produces the line interrupt and the frame interrupt, and it keeps the sprite overflow and sprite collision flags. The block does not count the beam position. The horizontal and vertical positions arrive as inputs from the timing generator. The sprite engine supplies one-cycle event pulses. The CPU side supplies status-read strobes, control-port write strobes and register writes.

Each flag is raised in two steps. An event first marks the flag as pending. The pending flag appears in the status byte only when it is promoted. Promotion happens in two cases:
- At the last dot of every line, all pending flags are promoted.
- When the CPU reads the status or writes the control port, a pending flag is promoted if the horizontal position has reached that flag's own threshold.

The interrupt output is a level signal. It is raised at fixed horizontal check points. A status read drops it. A write to an enable bit can raise it or drop it at once when the matching flag is visible.

Top module: `raster_irq_ctrl`

## Requirements
- R1: After reset the status byte is 0x00 and `irq` is 0. The line counter is 0. The line interval holds 0xFF, so the first line-flag event fires on line 0.
- R2: On the dot where `hpos` is 0 and `vpos` is at most ACTIVE_LINES, the line counter is tested:
  - If it is zero, it is reloaded from the interval and the line flag becomes pending.
  - Otherwise it decrements by one.
  - On lines after ACTIVE_LINES it is reloaded without marking anything.
- R3: The frame flag becomes pending at `hpos` 0 of the line whose `vpos` equals ACTIVE_LINES, and on no other line.
- R4: Status bit layout: bit 7 is the frame flag, bit 6 sprite overflow, bit 5 sprite collision, bit 1 the line flag. All other bits read 0.
- R5: At `hpos` 341 (the last dot), every pending flag is promoted. The `status` output shows the promoted value in that same cycle.
- R6: On a status read, control write or register write, a pending flag is promoted only if `hpos` is at least its threshold:
  - 25 for the line flag
  - 23 for the frame flag
  - 23 for overflow
  - 59 plus `spr_col_x` for collision
- R7: During a status read, `status` shows the byte returned. From the next cycle the four flags are 0 and `irq` is 0.
- R8: In the cycle after `hpos` is 25, `irq` is 1 if the line flag was pending or visible and the line enable (register 0, bit 4) is 1.
- R9: In the cycle after `hpos` is 24, `irq` is 1 if the frame flag was pending or visible and the frame enable (register 1, bit 5) is 1.
- R10: Register writes use `reg_idx` 0 (enable at bit 4), 1 (enable at bit 5) and 10 (interval).
  - A write to register 0 while the line flag is visible sets `irq` to the new bit 4.
  - A write to register 1 while the frame flag is visible sets `irq` to the new bit 5.
  - When the matching flag is clear, such a write leaves `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hpos | input | 9 | Horizontal dot position |
| vpos | input | 9 | Vertical line position |
| spr_ovr | input | 1 | Sprite overflow event pulse |
| spr_col | input | 1 | Sprite collision event pulse |
| spr_col_x | input | 8 | Collision x offset, valid with `spr_col` |
| status_rd | input | 1 | Status read strobe |
| ctrl_wr | input | 1 | Control-port write strobe (first byte) |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index |
| reg_data | input | 8 | Register write data |
| status | output | 8 | Status byte as returned by a read this cycle |
| irq | output | 1 | Level interrupt request |

## Verification
The bench walks line counter intervals of 0, 1, 2, 4, 11 and 12 over sixteen lines. This catches:
- an off-by-one reload, which shifts every later line flag by one line;
- a counter that keeps marking flags beyond the eligible lines.

The bench probes access-time promotion one dot either side of each threshold, and the end-of-line promotion with no access at all. A design that promoted eagerly would show flags before the CPU could legally see them. A design that promoted lazily at the wrong threshold would miss them.

Enable writes are issued with the matching flag set and with it clear. A design that ignores the flag condition would raise or drop `irq` spuriously.

// File: rtl/raster_irq_ctrl.sv
module raster_irq_ctrl #(
  parameter int HW           = 9,
  parameter int VW           = 9,
  parameter int XW           = 8,
  parameter int CW           = 8,
  parameter int LAST_H       = 341,
  parameter int ACTIVE_LINES = 192,
  parameter int LINE_VIS_H   = 25,
  parameter int FRAME_VIS_H  = 23,
  parameter int OVR_VIS_H    = 23,
  parameter int COL_BASE_H   = 59,
  parameter int LINE_CHK_H   = 25,
  parameter int FRAME_CHK_H  = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hpos,
  input  logic [VW-1:0] vpos,
  input  logic          spr_ovr,
  input  logic          spr_col,
  input  logic [XW-1:0] spr_col_x,
  input  logic          status_rd,
  input  logic          ctrl_wr,
  input  logic          reg_wr,
  input  logic [3:0]    reg_idx,
  input  logic [7:0]    reg_data,
  output logic [7:0]    status,
  output logic          irq
);

  localparam logic [HW-1:0] H_LAST      = HW'(LAST_H);
  localparam logic [HW-1:0] H_LINE_VIS  = HW'(LINE_VIS_H);
  localparam logic [HW-1:0] H_FRAME_VIS = HW'(FRAME_VIS_H);
  localparam logic [HW-1:0] H_OVR_VIS   = HW'(OVR_VIS_H);
  localparam logic [HW-1:0] H_COL_BASE  = HW'(COL_BASE_H);
  localparam logic [HW-1:0] H_LINE_CHK  = HW'(LINE_CHK_H);
  localparam logic [HW-1:0] H_FRAME_CHK = HW'(FRAME_CHK_H);
  localparam logic [VW-1:0] V_FRAME     = VW'(ACTIVE_LINES);

  logic          en_line, en_frame;
  logic [CW-1:0] interval, cnt;
  logic          p_line, p_frame, p_ovr, p_col;
  logic          f_line, f_frame, f_ovr, f_col;
  logic [HW-1:0] col_th;

  wire eol = (hpos == H_LAST);
  wire sol = (hpos == '0);
  wire acc = status_rd | ctrl_wr | reg_wr;

  wire pr_line  = p_line  & (eol | (acc & (hpos >= H_LINE_VIS)));
  wire pr_frame = p_frame & (eol | (acc & (hpos >= H_FRAME_VIS)));
  wire pr_ovr   = p_ovr   & (eol | (acc & (hpos >= H_OVR_VIS)));
  wire pr_col   = p_col   & (eol | (acc & (hpos >= col_th)));

  wire v_line  = f_line  | pr_line;
  wire v_frame = f_frame | pr_frame;
  wire v_ovr   = f_ovr   | pr_ovr;
  wire v_col   = f_col   | pr_col;

  assign status = {v_frame, v_ovr, v_col, 3'b000, v_line, 1'b0};

  wire eligible  = (vpos <= V_FRAME);
  wire cnt_zero  = (cnt == '0);
  wire set_line  = sol & eligible & cnt_zero;
  wire set_frame = sol & (vpos == V_FRAME);
  wire wr0  = reg_wr & (reg_idx == 4'd0);
  wire wr1  = reg_wr & (reg_idx == 4'd1);
  wire wr10 = reg_wr & (reg_idx == 4'd10);

  wire chk_line  = (hpos == H_LINE_CHK)  & (p_line  | f_line)  & en_line;
  wire chk_frame = (hpos == H_FRAME_CHK) & (p_frame | f_frame) & en_frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_line  <= 1'b0;
      en_frame <= 1'b0;
      interval <= '1;
      cnt      <= '0;
      p_line   <= 1'b0;
      p_frame  <= 1'b0;
      p_ovr    <= 1'b0;
      p_col    <= 1'b0;
      f_line   <= 1'b0;
      f_frame  <= 1'b0;
      f_ovr    <= 1'b0;
      f_col    <= 1'b0;
      col_th   <= '0;
      irq      <= 1'b0;
    end else begin
      p_line  <= (p_line  & ~pr_line)  | set_line;
      p_frame <= (p_frame & ~pr_frame) | set_frame;
      p_ovr   <= (p_ovr   & ~pr_ovr)   | spr_ovr;
      p_col   <= (p_col   & ~pr_col)   | spr_col;

      if (spr_col)     col_th <= H_COL_BASE + HW'(spr_col_x);
      else if (pr_col) col_th <= '0;

      f_line  <= v_line  & ~status_rd;
      f_frame <= v_frame & ~status_rd;
      f_ovr   <= v_ovr   & ~status_rd;
      f_col   <= v_col   & ~status_rd;

      if (sol) begin
        if (!eligible)     cnt <= interval;
        else if (cnt_zero) cnt <= interval;
        else               cnt <= cnt - CW'(1);
      end

      if (wr10) interval <= reg_data[CW-1:0];
      if (wr0)  en_line  <= reg_data[4];
      if (wr1)  en_frame <= reg_data[5];

      if (status_rd)                 irq <= 1'b0;
      else if (wr0 && v_line)        irq <= reg_data[4];
      else if (wr1 && v_frame)       irq <= reg_data[5];
      else if (chk_line | chk_frame) irq <= 1'b1;
    end
  end

  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> (!f_line && !f_frame && !f_ovr && !f_col && !irq));

  // R8
  line_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos == H_LINE_CHK && (p_line || f_line) && en_line && !status_rd && !reg_wr) |=> irq);

  // R9
  frame_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos == H_FRAME_CHK && (p_frame || f_frame) && en_frame && !status_rd && !reg_wr) |=> irq);

  // R2
  line_pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p_line) |-> ($past(hpos) == '0));

  // R6
  line_vis_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_line) |-> $past(p_line));

endmodule

// File: tb/raster_irq_ctrl_tb_top.sv
module raster_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] hpos = 9'd100;
  logic [8:0] vpos = 9'd20;
  logic       spr_ovr = 1'b0, spr_col = 1'b0;
  logic [7:0] spr_col_x = '0;
  logic       status_rd = 1'b0, ctrl_wr = 1'b0, reg_wr = 1'b0;
  logic [3:0] reg_idx = '0;
  logic [7:0] reg_data = '0;
  logic [7:0] status;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  raster_irq_ctrl #(.ACTIVE_LINES(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos),
    .spr_ovr(spr_ovr), .spr_col(spr_col), .spr_col_x(spr_col_x),
    .status_rd(status_rd), .ctrl_wr(ctrl_wr), .reg_wr(reg_wr),
    .reg_idx(reg_idx), .reg_data(reg_data),
    .status(status), .irq(irq)
  );

  // {line enable, interval}
  localparam logic [8:0] SCEN [0:5] = '{9'h100, 9'h001, 9'h102, 9'h004, 9'h00B, 9'h10C};

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual=%02h expected=%02h", what, got, exp);
    end
  endtask

  task automatic idle();
    hpos = 9'd100; vpos = 9'd20;
    status_rd = 0; ctrl_wr = 0; reg_wr = 0; spr_ovr = 0; spr_col = 0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    step(); step();
    rst_n = 1;
    step();
  endtask

  task automatic wr_reg(input logic [3:0] idx, input logic [7:0] d);
    reg_wr = 1; reg_idx = idx; reg_data = d;
    step();
    reg_wr = 0;
  endtask

  task automatic rd_stat();
    status_rd = 1;
    step();
    status_rd = 0;
  endtask

  task automatic run_line(input int v);
    for (int h = 0; h <= 341; h++) begin
      hpos = 9'(h); vpos = 9'(v);
      step();
    end
    idle();
  endtask

  task automatic scan_line(input int v, input int n, input bit en);
    bit exp_l;
    exp_l = (v <= 12) && ((v % (n + 1)) == 0);
    for (int h = 0; h <= 341; h++) begin
      hpos = 9'(h); vpos = 9'(v); status_rd = (h == 30);
      #1;
      if (h == 26) chk("R8 irq after line check", {7'b0, irq}, {7'b0, en && exp_l});
      if (h == 30) begin
        chk("R2 line flag on read", {7'b0, status[1]}, {7'b0, exp_l});
        chk("R3 frame flag on read", {7'b0, status[7]}, {7'b0, v == 12});
      end
      step();
    end
    idle();
  endtask

  initial begin
    do_reset();
    for (int s = 0; s < 6; s++) begin
      do_reset();
      wr_reg(4'd10, SCEN[s][7:0]);
      wr_reg(4'd0, SCEN[s][8] ? 8'h10 : 8'h00);
      for (int v = 0; v < 16; v++) scan_line(v, int'(SCEN[s][7:0]), SCEN[s][8]);
    end

    // R1 reset state and default interval
    do_reset();
    #1;
    chk("R1 status after reset", status, 8'h00);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    for (int v = 0; v < 3; v++) scan_line(v, 255, 1'b0);

    // R5/R6 lazy promotion of the line flag
    do_reset();
    for (int h = 0; h <= 23; h++) begin hpos = 9'(h); vpos = 0; step(); end
    hpos = 24; ctrl_wr = 1; #1;
    chk("R6 line flag below threshold", {7'b0, status[1]}, 8'h00);
    step(); ctrl_wr = 0;
    for (int h = 25; h <= 340; h++) begin hpos = 9'(h); step(); end
    #1;
    chk("R5 no promotion before line end", {7'b0, status[1]}, 8'h00);
    hpos = 341; #1;
    chk("R5 promotion at line end", {7'b0, status[1]}, 8'h01);
    step();
    idle(); #1;
    chk("R4 line flag at bit 1", status, 8'h02);
    status_rd = 1; #1;
    chk("R7 read returns byte", status, 8'h02);
    step(); status_rd = 0; #1;
    chk("R7 flags cleared after read", status, 8'h00);

    do_reset();
    for (int h = 0; h <= 24; h++) begin hpos = 9'(h); vpos = 0; step(); end
    hpos = 25; ctrl_wr = 1; #1;
    chk("R6 line flag at threshold", {7'b0, status[1]}, 8'h01);
    step(); ctrl_wr = 0; hpos = 26; #1;
    chk("R6 line flag held", {7'b0, status[1]}, 8'h01);

    // R6 overflow threshold 23
    do_reset();
    hpos = 5; spr_ovr = 1; step(); spr_ovr = 0;
    hpos = 22; status_rd = 1; #1;
    chk("R6 overflow below threshold", status, 8'h00);
    step();
    hpos = 23; #1;
    chk("R4 R6 overflow at bit 6", status, 8'h40);
    step(); status_rd = 0; #1;
    chk("R7 overflow cleared", status, 8'h00);

    // R6 collision threshold 59 + x
    do_reset();
    hpos = 5; spr_col = 1; spr_col_x = 8'd10; step(); spr_col = 0;
    hpos = 68; status_rd = 1; #1;
    chk("R6 collision below threshold", status, 8'h00);
    step();
    hpos = 69; #1;
    chk("R4 R6 collision at bit 5", status, 8'h20);
    step(); status_rd = 0;

    // R5 all pending promoted at line end without access
    do_reset();
    hpos = 5; spr_ovr = 1; spr_col = 1; spr_col_x = 8'd200; step();
    spr_ovr = 0; spr_col = 0;
    hpos = 300; #1;
    chk("R5 nothing visible mid line", status, 8'h00);
    hpos = 341; #1;
    chk("R5 sprite flags at line end", status, 8'h60);
    step();

    // R9 frame check at 24, R7 read drops irq
    do_reset();
    wr_reg(4'd1, 8'h20);
    for (int h = 0; h <= 23; h++) begin hpos = 9'(h); vpos = 12; step(); end
    hpos = 24; #1;
    chk("R9 irq low before frame check", {7'b0, irq}, 8'h00);
    step(); hpos = 25; #1;
    chk("R9 irq after frame check", {7'b0, irq}, 8'h01);
    step(); idle();
    rd_stat(); #1;
    chk("R7 irq dropped by read", {7'b0, irq}, 8'h00);

    // R8 line check at 25
    do_reset();
    wr_reg(4'd0, 8'h10);
    for (int h = 0; h <= 24; h++) begin hpos = 9'(h); vpos = 0; step(); end
    hpos = 25; #1;
    chk("R8 irq low before line check", {7'b0, irq}, 8'h00);
    step(); #1;
    chk("R8 irq after line check", {7'b0, irq}, 8'h01);

    // R10 enable writes
    do_reset();
    run_line(12);
    #1;
    chk("R4 frame and line flags", status, 8'h82);
    chk("R10 irq idle with enables off", {7'b0, irq}, 8'h00);
    wr_reg(4'd1, 8'h20); #1;
    chk("R10 frame enable raises irq", {7'b0, irq}, 8'h01);
    wr_reg(4'd1, 8'h00); #1;
    chk("R10 frame disable drops irq", {7'b0, irq}, 8'h00);
    wr_reg(4'd0, 8'h10); #1;
    chk("R10 line enable raises irq", {7'b0, irq}, 8'h01);
    wr_reg(4'd0, 8'h00); #1;
    chk("R10 line disable drops irq", {7'b0, irq}, 8'h00);
    rd_stat();
    wr_reg(4'd1, 8'h20); #1;
    chk("R10 enable with flag clear ignored", {7'b0, irq}, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule